// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

This block joins a big-endian processor bus to a 512-byte register window whose registers are a mix of byte, halfword and word wide. The processor may issue byte, halfword or word accesses to any register; the adapter looks up the native width of the addressed 4-byte group in a width table (a parameter) and turns the access into one or more accesses of exactly that width on the register side.

A processor access wider than the register becomes a run of native accesses at ascending addresses, the first carrying the most significant part. A read narrower than the register fetches the whole aligned register and hands back the addressed lane. A write narrower than the register becomes a fetch, a lane merge and a write-back, so that the other lanes keep their values. Accesses outside the window, to an unimplemented group, or with an illegal size code end at once with an error flag and zero data.

The processor holds its request until the one-cycle `cpu_ready` pulse. The sequencer has five states: IDLE (waits for and captures a request), PIECE (one native access per cycle for split or same-width accesses), FETCH (reads the register before a merge), STORE (writes the merged register back) and DONE (presents the response for one cycle). Transitions: IDLE to DONE on an error, IDLE to FETCH for a narrow write, IDLE to PIECE otherwise; PIECE repeats until the last piece and then goes to DONE; FETCH goes to STORE; STORE goes to DONE; DONE returns to IDLE.

Top module: `regbus_width_adapter`

## Requirements
- R1: Only the low 10 bits of `cpu_addr` are used; higher address bits have no effect on the access.
- R2: A masked offset of 0x200 or above, a group whose width code is 0, or a size code of 3 ends with `cpu_err`=1, `cpu_rdata`=0 and no register-side access, one edge after acceptance.
- R3: The width table holds 2 bits per group at bits [2g+1:2g], with group g = offset bits [8:2]; codes 1, 2 and 3 mean byte, halfword and word, and 0 means unimplemented. Every register-side access has `reg_size` equal to the group's width (0 byte, 1 halfword, 2 word) and an address aligned to that width.
- R4: When the access size equals the register width, one register access is made; data is right-justified on both sides (size codes 0 byte, 1 halfword, 2 word).
- R5: A byte read from a wider register reads the aligned register and returns the addressed byte, big-endian: the lowest address is the most significant byte.
- R6: A halfword read from a word register returns the upper half when offset bits [1:0] are 0 and the lower half when they are 2.
- R7: An access wider than the register is made as size/width register accesses at ascending addresses, the lowest address carrying the most significant part; a word to a byte register takes four accesses.
- R8: A write narrower than the register reads the aligned register, replaces only the addressed lane and writes the register back at the same address; the other lanes are unchanged.
- R9: `cpu_ready` is a one-cycle pulse, high after 1+k clock edges counted from the first edge that sees the request in IDLE, where k is the number of register-side accesses (0 on error, 2 for a narrow write, otherwise the piece count); writes return zero data.
- R10: Address bits below the access size are ignored: halfword accesses clear bit 0 and word accesses clear bits [1:0].
- R11: During and after reset with no request, `cpu_ready` and `reg_sel` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Byte address, low 10 bits used |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Error flag, valid with `cpu_ready` |
| cpu_rdata | output | 32 | Right-justified read data, valid with `cpu_ready` |
| reg_sel | output | 1 | Register-side access this cycle |
| reg_we | output | 1 | Register-side write |
| reg_size | output | 2 | Native width of the access |
| reg_addr | output | WIN_W | Register byte address, aligned |
| reg_wdata | output | 32 | Right-justified register write data |
| reg_rdata | input | 32 | Right-justified register read data, same cycle |

## Verification
Each response is due exactly 1+k clock edges after the edge that accepts the request, with k taken from the group width and access size as stated in R9. The bench computes k and the expected data from its own model, counts edges one at a time while sampling `cpu_ready` on the falling edge, and compares the edge count, the error flag, the data and the number of register-side accesses at that point. Register contents are compared byte by byte against the model after every access, which covers lane preservation in merges.

// File: rtl/wadp_pkg.sv
package wadp_pkg;

    // access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // width table codes
    localparam logic [1:0] WC_NONE = 2'd0;
    localparam logic [1:0] WC_BYTE = 2'd1;
    localparam logic [1:0] WC_HALF = 2'd2;
    localparam logic [1:0] WC_WORD = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIECE,
        ST_FETCH,
        ST_STORE,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic       err;
        logic       wr;
        logic       narrow;
        logic [1:0] nsz;
        logic [1:0] asz;
        logic [2:0] pieces;
        logic [1:0] off;
    } plan_t;

    // default table: groups cycle through byte, half, word, unimplemented
    function automatic logic [255:0] build_map();
        logic [255:0] m;
        m = '0;
        for (int g = 0; g < 128; g++) begin
            unique case (g % 4)
                0:       m[2*g +: 2] = WC_BYTE;
                1:       m[2*g +: 2] = WC_HALF;
                2:       m[2*g +: 2] = WC_WORD;
                default: m[2*g +: 2] = WC_NONE;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/wadp_decode.sv
module wadp_decode
    import wadp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GROUPS = 128,
    parameter logic [2*GROUPS-1:0] WIDTH_MAP = build_map()
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [1:0]                     size,
    input  logic                           we,
    output plan_t                          plan,
    output logic [$clog2(GROUPS)+1:0]      base
);
    localparam int GA_W   = $clog2(GROUPS);
    localparam int WIN_W  = GA_W + 2;
    localparam int MASK_W = WIN_W + 1;

    logic [MASK_W-1:0] masked;
    logic [GA_W-1:0]   grp;
    logic [1:0]        code;
    logic [WIN_W-1:0]  al;
    logic              unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:MASK_W];

    always_comb begin
        masked = addr[MASK_W-1:0];
        grp    = masked[WIN_W-1:2];
        code   = WIDTH_MAP[{grp, 1'b0} +: 2];
        al     = masked[WIN_W-1:0];
        if (size == SZ_HALF) al[0] = 1'b0;
        if (size == SZ_WORD) al[1:0] = 2'b00;

        plan.err    = masked[MASK_W-1] | (code == WC_NONE) | (size == 2'd3);
        plan.wr     = we;
        plan.nsz    = (code == WC_NONE) ? SZ_BYTE : code - 2'd1;
        plan.asz    = (size == 2'd3) ? SZ_BYTE : size;
        plan.narrow = 1'b0;
        plan.pieces = 3'd1;
        plan.off    = 2'b00;
        base        = al;
        if (plan.asz > plan.nsz) begin
            plan.pieces = 3'(1 << (plan.asz - plan.nsz));
        end else begin
            plan.narrow = plan.asz < plan.nsz;
            unique case (plan.nsz)
                SZ_HALF: begin base[0]   = 1'b0;  plan.off = {1'b0, al[0]}; end
                SZ_WORD: begin base[1:0] = 2'b00; plan.off = al[1:0];       end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wadp_lane.sv
module wadp_lane (
    input  logic [1:0]  nsz,
    input  logic [1:0]  asz,
    input  logic [1:0]  off,
    input  logic [31:0] rd_live,
    input  logic [31:0] rd_hold,
    input  logic [31:0] wdata,
    output logic [31:0] ext,
    output logic [31:0] merged
);
    logic [5:0]  shamt;
    logic [31:0] amask;

    always_comb begin
        int nb;
        int ab;
        int sh;
        nb = 1 << nsz;
        ab = 1 << asz;
        sh = (nb - ab - int'(off)) * 8;
        if (sh < 0) sh = 0;
        shamt = 6'(sh);
        unique case (asz)
            2'd0:    amask = 32'h0000_00ff;
            2'd1:    amask = 32'h0000_ffff;
            default: amask = 32'hffff_ffff;
        endcase
        ext    = (rd_live >> shamt) & amask;
        merged = (rd_hold & ~(amask << shamt)) | ((wdata & amask) << shamt);
    end

endmodule

// File: rtl/wadp_seq.sv
module wadp_seq
    import wadp_pkg::*;
#(
    parameter int WIN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [31:0]      req_wdata,
    input  plan_t            plan,
    input  logic [WIN_W-1:0] base,
    input  logic [31:0]      reg_rdata,
    input  logic [31:0]      ext,
    input  logic [31:0]      merged,
    output plan_t            pl_q,
    output logic [31:0]      acc_q,
    output logic [31:0]      wd_q,
    output logic             reg_sel,
    output logic             reg_we,
    output logic [1:0]       reg_size,
    output logic [WIN_W-1:0] reg_addr,
    output logic [31:0]      reg_wdata,
    output logic             rsp_ready,
    output logic             rsp_err,
    output logic [31:0]      rsp_rdata
);
    state_e           state, state_n;
    logic [WIN_W-1:0] base_q;
    logic [2:0]       idx_q;
    logic [5:0]       nbits;
    logic [31:0]      nmask;
    logic             last_piece;

    always_comb begin
        nbits = 6'(8 << pl_q.nsz);
        unique case (pl_q.nsz)
            2'd0:    nmask = 32'h0000_00ff;
            2'd1:    nmask = 32'h0000_ffff;
            default: nmask = 32'hffff_ffff;
        endcase
        last_piece = (idx_q == pl_q.pieces - 3'd1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (req) begin
                if (plan.err)                    state_n = ST_DONE;
                else if (plan.narrow && plan.wr) state_n = ST_FETCH;
                else                             state_n = ST_PIECE;
            end
            ST_PIECE: if (last_piece) state_n = ST_DONE;
            ST_FETCH: state_n = ST_STORE;
            ST_STORE: state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // captured request and assembled data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q   <= '0;
            base_q <= '0;
            wd_q   <= '0;
            acc_q  <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    pl_q   <= plan;
                    base_q <= base;
                    wd_q   <= req_wdata;
                    acc_q  <= '0;
                    idx_q  <= '0;
                end
                ST_PIECE: begin
                    idx_q <= idx_q + 3'd1;
                    if (!pl_q.wr) begin
                        if (pl_q.narrow) acc_q <= ext;
                        else             acc_q <= (acc_q << nbits) | (reg_rdata & nmask);
                    end
                end
                ST_FETCH: acc_q <= reg_rdata;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        logic [WIN_W-1:0] step;
        int               ps;
        step      = WIN_W'(idx_q) << pl_q.nsz;
        ps        = (int'(pl_q.pieces) - 1 - int'(idx_q)) * int'(nbits);
        if (ps < 0) ps = 0;
        reg_sel   = 1'b0;
        reg_we    = 1'b0;
        reg_size  = pl_q.nsz;
        reg_addr  = base_q;
        reg_wdata = '0;
        rsp_ready = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state)
            ST_PIECE: begin
                reg_sel   = 1'b1;
                reg_we    = pl_q.wr;
                reg_addr  = base_q + step;
                reg_wdata = pl_q.wr ? ((wd_q >> ps) & nmask) : '0;
            end
            ST_FETCH: reg_sel = 1'b1;
            ST_STORE: begin
                reg_sel   = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = merged;
            end
            ST_DONE: begin
                rsp_ready = 1'b1;
                rsp_err   = pl_q.err;
                rsp_rdata = (pl_q.err || pl_q.wr) ? '0 : acc_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/regbus_width_adapter.sv
module regbus_width_adapter
    import wadp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GROUPS = 128,
    parameter logic [2*GROUPS-1:0] WIDTH_MAP = build_map(),
    localparam int WIN_W = $clog2(GROUPS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_err,
    output logic [31:0]       cpu_rdata,
    output logic              reg_sel,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [WIN_W-1:0]  reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);
    plan_t            plan, pl_q;
    logic [WIN_W-1:0] base;
    logic [31:0]      acc_q, wd_q, ext, merged;

    wadp_decode #(
        .ADDR_W(ADDR_W), .GROUPS(GROUPS), .WIDTH_MAP(WIDTH_MAP)
    ) u_decode (
        .addr(cpu_addr), .size(cpu_size), .we(cpu_we),
        .plan(plan), .base(base)
    );

    wadp_seq #(.WIN_W(WIN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req(cpu_req), .req_wdata(cpu_wdata),
        .plan(plan), .base(base),
        .reg_rdata(reg_rdata), .ext(ext), .merged(merged),
        .pl_q(pl_q), .acc_q(acc_q), .wd_q(wd_q),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rsp_ready(cpu_ready), .rsp_err(cpu_err), .rsp_rdata(cpu_rdata)
    );

    wadp_lane u_lane (
        .nsz(pl_q.nsz), .asz(pl_q.asz), .off(pl_q.off),
        .rd_live(reg_rdata), .rd_hold(acc_q), .wdata(wd_q),
        .ext(ext), .merged(merged)
    );

endmodule

// File: rtl/wadp_chk.sv
module wadp_chk #(
    parameter int GROUPS = 128,
    parameter logic [2*GROUPS-1:0] WIDTH_MAP = '0,
    localparam int WIN_W = $clog2(GROUPS) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_we,
    input logic [1:0]       reg_size,
    input logic [WIN_W-1:0] reg_addr,
    input logic             cpu_ready,
    input logic             cpu_err,
    input logic [31:0]      cpu_rdata
);
    logic [1:0] code_at;
    assign code_at = WIDTH_MAP[{reg_addr[WIN_W-1:2], 1'b0} +: 2];

    assert_native_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (code_at != 2'd0) && (reg_size == 2'(code_at - 2'd1)));

    assert_native_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_size == 2'd0) || (reg_size == 2'd1 && !reg_addr[0])
                    || (reg_size == 2'd2 && reg_addr[1:0] == 2'b00));

    assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_err) |-> (cpu_rdata == 32'd0));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !reg_sel);

    assert_rmw_same_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && $past(reg_sel) && !$past(reg_we))
            |-> (reg_addr == $past(reg_addr)));

endmodule

bind regbus_width_adapter wadp_chk #(
    .GROUPS(GROUPS), .WIDTH_MAP(WIDTH_MAP)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_size(reg_size), .reg_addr(reg_addr),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata)
);

// File: tb/sim_regbus_width_adapter.sv
`timescale 1ns/1ps
module sim_regbus_width_adapter;
    localparam logic [255:0] MAP = wadp_pkg::build_map();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_err;
    logic [31:0] cpu_rdata;
    logic        reg_sel, reg_we;
    logic [1:0]  reg_size;
    logic [8:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    logic [7:0] mem [512];
    logic [7:0] shadow [512];
    int sub_cnt;
    int vecs = 0;
    int errs = 0;

    always #10 clk = ~clk;

    regbus_width_adapter u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // register file model, big-endian, combinational read
    always_comb begin
        unique case (reg_size)
            2'd0:    reg_rdata = {24'h0, mem[reg_addr]};
            2'd1:    reg_rdata = {16'h0, mem[reg_addr], mem[9'(reg_addr + 9'd1)]};
            default: reg_rdata = {mem[reg_addr], mem[9'(reg_addr + 9'd1)],
                                  mem[9'(reg_addr + 9'd2)], mem[9'(reg_addr + 9'd3)]};
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= init_byte(i);
            sub_cnt <= 0;
        end else if (reg_sel) begin
            sub_cnt <= sub_cnt + 1;
            if (reg_we) begin
                unique case (reg_size)
                    2'd0: mem[reg_addr] <= reg_wdata[7:0];
                    2'd1: begin
                        mem[reg_addr] <= reg_wdata[15:8];
                        mem[9'(reg_addr + 9'd1)] <= reg_wdata[7:0];
                    end
                    default: begin
                        mem[reg_addr] <= reg_wdata[31:24];
                        mem[9'(reg_addr + 9'd1)] <= reg_wdata[23:16];
                        mem[9'(reg_addr + 9'd2)] <= reg_wdata[15:8];
                        mem[9'(reg_addr + 9'd3)] <= reg_wdata[7:0];
                    end
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_access(input logic we, input logic [1:0] sz, input logic [15:0] addr,
                             input logic [31:0] wd, input string tag_in);
        int g, code, n, nb, al, k, start, edges;
        bit err, got, same;
        logic [31:0] exp_rd, wdm, act_rd;
        logic act_err;
        string tag;
        g    = int'(addr[8:2]);
        code = int'(MAP[2*g +: 2]);
        err  = addr[9] || code == 0 || sz == 2'd3;
        n    = (code == 0) ? 0 : code - 1;
        nb   = 1 << sz;
        al   = int'(addr[8:0]) & ~(nb - 1);
        if (err)          k = 0;
        else if (sz > n)  k = 1 << (int'(sz) - n);
        else if (we && sz < n) k = 2;
        else              k = 1;
        if (tag_in != "")    tag = tag_in;
        else if (err)        tag = "R2";
        else if (sz == n)    tag = "R4";
        else if (sz > n)     tag = "R7";
        else if (we)         tag = "R8";
        else if (sz == 2'd0) tag = "R5";
        else                 tag = "R6";
        exp_rd = '0;
        wdm = (sz == 2'd0) ? (wd & 32'hff) : (sz == 2'd1) ? (wd & 32'hffff) : wd;
        if (!err && !we)
            for (int i = 0; i < nb; i++) exp_rd = (exp_rd << 8) | 32'(shadow[al + i]);
        if (!err && we)
            for (int i = 0; i < nb; i++) shadow[al + i] = 8'(wdm >> (8 * (nb - 1 - i)));

        @(negedge clk);
        start     = sub_cnt;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_size  = sz;
        cpu_addr  = addr;
        cpu_wdata = wd;
        edges = 0;
        got   = 0;
        while (!got && edges < 40) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (cpu_ready) got = 1;
        end
        act_rd  = cpu_rdata;
        act_err = cpu_err;
        cpu_req = 1'b0;

        check(got && edges == 1 + k, "R9", "response edge count", 32'(edges), 32'(1 + k));
        check(act_err == err, err ? "R2" : tag, "error flag", 32'(act_err), 32'(err));
        check(act_rd == exp_rd, tag, "read data", act_rd, exp_rd);
        check(sub_cnt - start == k, err ? "R2" : tag, "register access count",
              32'(sub_cnt - start), 32'(k));
        same = 1;
        for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) same = 0;
        check(same, (we && !err && sz < n) ? "R8" : tag, "register contents", 32'(same), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = int'($urandom(32'd20517));
        for (int i = 0; i < 512; i++) shadow[i] = init_byte(i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cpu_ready && !reg_sel, "R11", "in reset ready/sel", {cpu_ready, reg_sel}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!cpu_ready && !reg_sel, "R11", "idle ready/sel", {cpu_ready, reg_sel}, 32'd0);

        // directed: group 0 byte, 1 half, 2 word, 3 unimplemented (repeating)
        do_access(1'b0, 2'd0, 16'h0004, 32'h0, "R5");
        do_access(1'b0, 2'd0, 16'h0005, 32'h0, "R5");
        do_access(1'b0, 2'd0, 16'h000a, 32'h0, "R5");
        do_access(1'b0, 2'd1, 16'h0008, 32'h0, "R6");
        do_access(1'b0, 2'd1, 16'h000a, 32'h0, "R6");
        do_access(1'b0, 2'd2, 16'h0000, 32'h0, "R7");
        do_access(1'b0, 2'd2, 16'h0004, 32'h0, "R7");
        do_access(1'b1, 2'd1, 16'h0002, 32'h0000_a55a, "R7");
        do_access(1'b1, 2'd2, 16'h0010, 32'h1234_5678, "R7");
        do_access(1'b0, 2'd2, 16'h0010, 32'h0, "R7");
        do_access(1'b1, 2'd0, 16'h0009, 32'h0000_00c3, "R8");
        do_access(1'b1, 2'd0, 16'h0007, 32'h0000_003c, "R8");
        do_access(1'b1, 2'd1, 16'h000a, 32'h0000_beef, "R8");
        do_access(1'b0, 2'd2, 16'h0008, 32'h0, "R8");
        do_access(1'b1, 2'd2, 16'h0018, 32'hcafe_f00d, "R4");
        do_access(1'b1, 2'd1, 16'h0014, 32'h0000_7e81, "R4");
        do_access(1'b0, 2'd0, 16'h0001, 32'h0, "R4");
        do_access(1'b0, 2'd0, 16'h000c, 32'h0, "R2");
        do_access(1'b1, 2'd2, 16'h0200, 32'hffff_ffff, "R2");
        do_access(1'b0, 2'd3, 16'h0004, 32'h0, "R2");
        do_access(1'b0, 2'd2, 16'hf008, 32'h0, "R1");
        do_access(1'b1, 2'd0, 16'h7c05, 32'h0000_0099, "R1");
        do_access(1'b0, 2'd1, 16'h0009, 32'h0, "R10");
        do_access(1'b0, 2'd2, 16'h0013, 32'h0, "R10");

        // constrained random
        for (int t = 0; t < 800; t++) begin
            logic [15:0] a;
            logic [1:0]  s;
            a    = 16'($urandom);
            a[9] = ($urandom % 8) == 0;
            s    = (($urandom % 32) == 0) ? 2'd3 : 2'(($urandom % 3));
            do_access(1'($urandom), s, a, $urandom, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule